// File: doc/BRIEF.md
# Page Write Collector and Program Sequencer

This block sits behind a serial memory front end. It gathers the data bytes of one write session into a one-page staging buffer. When chip select is released, it copies those bytes into a byte-wide storage array. A session opens with a start strobe that carries a 16-bit address. Only the low `ADDR_W` bits of that address select a location. Every byte strobe that follows stores one byte and moves the in-page offset forward. The page number never changes during a session. When the offset runs past the end of the page, it wraps back to the start of the same page.

A release strobe ends the session. If at least one byte was loaded, the block raises `busy_o` for a fixed number of clock cycles, which stands in for the self-timed program time. During the first `PAGE_BYTES` of those cycles it scans the page once in ascending order. It issues one array write for each position that received a byte and skips every other position. When the cycle ends, the block gives a single-cycle pulse that tells the surrounding logic to clear its write-enable latch. While `busy_o` is high, every session input is ignored.

Top module: `page_writer`

## Requirements
- R1: After reset, `busy_o`, `wel_clr_o` and `mem_we_o` are 0.
- R2: Address bits at and above bit `ADDR_W` (12) of `start_addr_i` have no effect; the location written is `start_addr_i[11:0]` advanced by the byte count.
- R3: Successive bytes of a session go to offsets (`start_addr_i[4:0]` + k) mod 32 inside the page `start_addr_i[11:5]`; the page field never changes.
- R4: When more than 32 bytes are loaded, the offset wraps, and a later byte at an offset replaces the earlier one; only the last value is written.
- R5: No array write and no busy occur while bytes are being loaded; `busy_o` rises in the cycle right after the release strobe is sampled.
- R6: `busy_o` stays high for exactly `max(PROG_CYCLES, PAGE_BYTES)` consecutive cycles.
- R7: `wel_clr_o` is high for exactly one cycle, the first cycle after `busy_o` falls.
- R8: In busy cycle j (j = 0 … 31), `mem_we_o` is 1 exactly when offset j was loaded, with `mem_addr_o` = {page, j} and `mem_data_o` holding that byte; there are no writes outside busy.
- R9: A release strobe after a session with zero bytes, or with no open session, starts no program cycle and gives no `wel_clr_o` pulse.
- R10: Start, byte and release strobes that arrive while `busy_o` is high are ignored: the running writes and the busy length are unchanged, and no session is open afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Opens a write session |
| start_addr_i | input | ADDR_IN_W (16) | Session start address; upper bits ignored |
| byte_vld_i | input | 1 | Data byte strobe |
| byte_i | input | 8 | Data byte |
| cs_rise_i | input | 1 | Chip-select release strobe; commits the session |
| busy_o | output | 1 | Program cycle in progress |
| wel_clr_o | output | 1 | One-cycle pulse: clear write enable |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | ADDR_W (12) | Array write address |
| mem_data_o | output | 8 | Array write data |

## Verification
The release strobe is driven on one falling edge and sampled on the next rising edge. `busy_o` is checked high from the following falling edge onward. Busy cycle j is checked on the j-th falling edge after commit, and that sample must show the write for offset j, or no write at all. `busy_o` must read low, with `wel_clr_o` high, on the sample taken `max(PROG_CYCLES, PAGE_BYTES)` cycles after the first busy sample. `wel_clr_o` must be low again one sample later. While bytes are loading, each sample confirms that no write and no busy has appeared yet. After a rejected commit, three samples confirm that nothing started.

// File: rtl/page_writer.sv
`timescale 1ns/1ps
module page_writer #(
  parameter int ADDR_IN_W   = 16,
  parameter int ADDR_W      = 12,
  parameter int PAGE_BYTES  = 32,
  parameter int PROG_CYCLES = 250000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [ADDR_IN_W-1:0] start_addr_i,
  input  logic                 byte_vld_i,
  input  logic [7:0]           byte_i,
  input  logic                 cs_rise_i,
  output logic                 busy_o,
  output logic                 wel_clr_o,
  output logic                 mem_we_o,
  output logic [ADDR_W-1:0]    mem_addr_o,
  output logic [7:0]           mem_data_o
);
  localparam int OFF_W    = $clog2(PAGE_BYTES);
  localparam int PAGE_W   = ADDR_W - OFF_W;
  localparam int PROG_LEN = (PROG_CYCLES < PAGE_BYTES) ? PAGE_BYTES : PROG_CYCLES;
  localparam int CNT_W    = $clog2(PROG_LEN);

  logic                  loading_q;
  logic [PAGE_W-1:0]     page_q;
  logic [OFF_W-1:0]      ptr_q;
  logic [PAGE_BYTES-1:0] mask_q;
  logic [7:0]            buf_q [PAGE_BYTES];
  logic                  busy_q;
  logic [CNT_W-1:0]      cnt_q;
  logic [OFF_W:0]        scan_q;
  logic                  wel_clr_q;

  wire unused_hi = ^start_addr_i[ADDR_IN_W-1:ADDR_W];
  wire take      = !busy_q && !cs_rise_i && !start_i && loading_q && byte_vld_i;
  wire scan_live = busy_q && !scan_q[OFF_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loading_q <= 1'b0;
      page_q    <= '0;
      ptr_q     <= '0;
      mask_q    <= '0;
      busy_q    <= 1'b0;
      cnt_q     <= '0;
      scan_q    <= '0;
      wel_clr_q <= 1'b0;
    end else begin
      wel_clr_q <= 1'b0;
      if (busy_q) begin
        if (!scan_q[OFF_W]) scan_q <= scan_q + 1'b1;
        if (cnt_q == '0) begin
          busy_q    <= 1'b0;
          wel_clr_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else if (cs_rise_i) begin
        loading_q <= 1'b0;
        if (loading_q && |mask_q) begin
          busy_q <= 1'b1;
          cnt_q  <= CNT_W'(PROG_LEN - 1);
          scan_q <= '0;
        end
      end else if (start_i) begin
        loading_q <= 1'b1;
        page_q    <= start_addr_i[ADDR_W-1:OFF_W];
        ptr_q     <= start_addr_i[OFF_W-1:0];
        mask_q    <= '0;
      end else if (loading_q && byte_vld_i) begin
        mask_q[ptr_q] <= 1'b1;
        ptr_q         <= ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take) buf_q[ptr_q] <= byte_i;
  end

  assign busy_o     = busy_q;
  assign wel_clr_o  = wel_clr_q;
  assign mem_we_o   = scan_live && mask_q[scan_q[OFF_W-1:0]];
  assign mem_addr_o = {page_q, scan_q[OFF_W-1:0]};
  assign mem_data_o = buf_q[scan_q[OFF_W-1:0]];
endmodule

// File: rtl/page_writer_chk.sv
`timescale 1ns/1ps
module page_writer_chk #(
  parameter int PROG_LEN   = 32,
  parameter int PAGE_BYTES = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cs_rise_i,
  input logic                  busy_o,
  input logic                  wel_clr_o,
  input logic                  mem_we_o,
  input logic                  loading_q,
  input logic [PAGE_BYTES-1:0] mask_q
);
  int unsigned run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_len <= 0;
    else if (busy_o) run_len <= run_len + 1;
    else             run_len <= 0;
  end

  p_we_in_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> busy_o);

  p_busy_from_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(cs_rise_i) && $past(loading_q));

  p_empty_no_prog_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && cs_rise_i && mask_q == '0) |=> !busy_o);

  p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> run_len == PROG_LEN);

  p_wel_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr_o |-> !busy_o && $past(busy_o));

  p_wel_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr_o |=> !wel_clr_o);
endmodule

bind page_writer page_writer_chk #(.PROG_LEN(PROG_LEN), .PAGE_BYTES(PAGE_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_rise_i(cs_rise_i), .busy_o(busy_o),
  .wel_clr_o(wel_clr_o), .mem_we_o(mem_we_o), .loading_q(loading_q), .mask_q(mask_q)
);

// File: tb/sim_page_writer.sv
`timescale 1ns/1ps
module sim_page_writer;
  localparam int PROG = 40;
  localparam int PB   = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] start_addr_i = '0;
  logic        byte_vld_i = 1'b0;
  logic [7:0]  byte_i = '0;
  logic        cs_rise_i = 1'b0;
  logic        busy_o, wel_clr_o, mem_we_o;
  logic [11:0] mem_addr_o;
  logic [7:0]  mem_data_o;

  page_writer #(.PROG_CYCLES(PROG)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i), .cs_rise_i(cs_rise_i),
    .busy_o(busy_o), .wel_clr_o(wel_clr_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o)
  );

  always #10 clk = ~clk;

  int        vectors = 0;
  int        errs = 0;
  logic [7:0] exp_data [PB];
  logic [PB-1:0] exp_mask;
  logic [7:0] seq [64];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] slot_of(input logic [15:0] a, input int k);
    return 5'((int'(a[4:0]) + k) % PB);
  endfunction

  task automatic quiet(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk({req, " busy"}, busy_o, 0);
      chk({req, " wel"}, wel_clr_o, 0);
      chk({req, " we"}, mem_we_o, 0);
    end
  endtask

  task automatic session(input logic [15:0] a, input int n, input bit inject);
    exp_mask = '0;
    for (int k = 0; k < n; k++) begin
      seq[k] = 8'($urandom);
      exp_data[slot_of(a, k)] = seq[k];
      exp_mask[slot_of(a, k)] = 1'b1;
    end
    @(negedge clk);
    start_i = 1'b1; start_addr_i = a;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < n; k++) begin
      byte_vld_i = 1'b1; byte_i = seq[k];
      @(negedge clk);
      chk("R5 no busy while loading", busy_o, 0);
      chk("R5 no write while loading", mem_we_o, 0);
    end
    byte_vld_i = 1'b0;
    cs_rise_i = 1'b1;
    @(negedge clk);
    cs_rise_i = 1'b0;
    if (n == 0) begin
      chk("R9 empty commit busy", busy_o, 0);
      quiet(3, "R9");
      return;
    end
    for (int j = 0; j < PROG; j++) begin
      logic ew;
      ew = (j < PB) && exp_mask[j % PB];
      chk("R6 busy held", busy_o, 1);
      chk("R8 write enable per slot", mem_we_o, ew);
      if (ew) begin
        chk("R2 R3 write address", mem_addr_o, {a[11:5], 5'(j)});
        chk("R4 write data", mem_data_o, exp_data[j]);
      end
      if (inject) begin
        start_i    = (j == 4);
        start_addr_i = 16'h0123;
        byte_vld_i = (j == 6 || j == 7);
        byte_i     = 8'hEE;
        cs_rise_i  = (j == 9);
      end
      @(negedge clk);
    end
    start_i = 1'b0; byte_vld_i = 1'b0; cs_rise_i = 1'b0;
    chk("R6 busy ends", busy_o, 0);
    chk("R7 wel pulse", wel_clr_o, 1);
    @(negedge clk);
    chk("R7 wel single", wel_clr_o, 0);
    chk("R6 stays idle", busy_o, 0);
  endtask

  initial begin
    #(20 * 150000);
    errs++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk);
    chk("R1 reset busy", busy_o, 0);
    chk("R1 reset wel", wel_clr_o, 0);
    chk("R1 reset we", mem_we_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    quiet(2, "R1");

    session(16'h0040, 1, 0);
    session(16'hF7FE, 5, 0);
    session(16'h0FE0, 32, 0);
    session(16'h3A1C, 37, 0);
    session(16'h0100, 0, 0);

    @(negedge clk);
    cs_rise_i = 1'b1;
    @(negedge clk);
    cs_rise_i = 1'b0;
    quiet(3, "R9 no session");

    session(16'h0222, 3, 1);
    @(negedge clk);
    cs_rise_i = 1'b1;
    @(negedge clk);
    cs_rise_i = 1'b0;
    quiet(3, "R10 no session after busy");

    for (int s = 0; s < 25; s++)
      session(16'($urandom), 1 + int'($urandom % 40), 0);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule